// File: doc/BRIEF.md
# GPIO Interrupt Aggregator

This block is the qualification stage between a bank of up to 32 peripheral interrupt wires and a single request input of a processor interrupt controller. Every wire first crosses into the local clock domain through a flop synchroniser. A debounce filter then accepts a new value only after the synchronised value has held steady for a programmable number of cycles. The filtered value is then turned into a per-line request, either as a level of selectable polarity or as a latched edge of selectable direction. Requests that are enabled and unmasked are OR-ed into one output.

Software programs the block through a simple register port that carries a valid, a write flag, an address and 32-bit data. Reads are combinational from the address. The usual bring-up runs in a fixed order. All lines are masked first. The lines that have a real source are then unmasked, here lines 0, 2 and 3, pattern 0x0D. Type and polarity are written next, and the lines are enabled last. Lines without a source stay masked and can never raise the output.

Top module: `irq_debounce_agg`

## Requirements
- R1: After reset the block holds these values: line enable 0, mask all ones, type 0, polarity all ones, debounce length 2, both status words 0, and `irq_out` low.
- R2: The control words read back what was written at these offsets: 0x30 line enable, 0x34 mask, 0x38 type, 0x3C polarity, and 0x48 debounce length in the low 8 bits. The edge-clear offset 0x4C and any unmapped offset read 0.
- R3: With type bit n = 0 the line is level sensitive. If polarity bit n = 1 it is active while the filtered input is high; if polarity bit n = 0 it is active while the input is low. Raw status at 0x44 bit n shows the request.
- R4: A mask bit of 1 removes that line from the masked status at 0x40 and from `irq_out`, while raw status at 0x44 still shows the line.
- R5: An enable bit of 0 forces that line's raw status to 0 and discards any latched edge. Re-enabling the line does not restore a discarded edge.
- R6: With type bit n = 1 the line latches an edge. Polarity bit n = 1 latches a rising edge and 0 latches a falling edge. The latch stays set after the input returns to its idle level.
- R7: Writing a 1 to bit n at offset 0x4C clears the edge latch of line n. Bits written as 0 leave their latches unchanged.
- R8: With debounce length L (L = 0 acts as 1), a change on `irq_in` reaches `irq_out` on the L+2-th rising clock edge after the change. A change that lasts fewer than L synchronised cycles is never accepted.
- R9: `irq_out` is high exactly when the masked status at 0x40 is nonzero.
- R10: After the bring-up sequence with pattern 0x0D, activity on unconnected lines leaves `irq_out` and both status words at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (8) | Byte offset of the register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| irq_in | input | NLINES (32) | Asynchronous peripheral interrupt wires |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench counts the exact latency from an input change to `irq_out`, at both the programmed length and at length zero. An off-by-one counter in the filter would raise the request a cycle early or late, and a filter that treated zero literally would never accept any change. It sends glitches shorter than the window, which a filter that did not restart its count would let through. It covers latched edges in both directions. A clear written to a different bit must leave the latch alone. Disabling a line must drop its latched edge for good, so a design that only gated the latch would show the edge again on re-enable. It also checks that masked and raw status differ on a masked line and that unconnected lines stay silent after bring-up.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   // register byte offsets (software decodes these)
   localparam int unsigned OFS_ENABLE = 32'h30;
   localparam int unsigned OFS_MASK   = 32'h34;
   localparam int unsigned OFS_TYPE   = 32'h38;
   localparam int unsigned OFS_POL    = 32'h3C;
   localparam int unsigned OFS_STAT   = 32'h40;
   localparam int unsigned OFS_RAW    = 32'h44;
   localparam int unsigned OFS_DBNC   = 32'h48;
   localparam int unsigned OFS_ECLR   = 32'h4C;
endpackage

// File: rtl/irq_sync_debounce.sv
module irq_sync_debounce #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [CNT_W-1:0] limit,
   output logic             dout
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_sh;
   logic                   s_val;
   logic                   f_val;
   logic [CNT_W-1:0]       run_cnt;
   logic [CNT_W:0]         run_nxt;
   logic [CNT_W:0]         lim_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_sh <= '0;
      else        sync_sh <= {sync_sh[SYNC_STAGES-2:0], din};
   end
   assign s_val = sync_sh[SYNC_STAGES-1];

   assign run_nxt = {1'b0, run_cnt} + 1'b1;
   assign lim_eff = (limit == '0) ? (CNT_W+1)'(1) : {1'b0, limit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_val   <= 1'b0;
         run_cnt <= '0;
      end else if (s_val == f_val) begin
         run_cnt <= '0;
      end else if (run_nxt >= lim_eff) begin
         f_val   <= s_val;
         run_cnt <= '0;
      end else begin
         run_cnt <= run_nxt[CNT_W-1:0];
      end
   end
   assign dout = f_val;

   // R8: filtered value holds while the synchronised input agrees with it
   p_filter_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s_val == f_val) |=> $stable(f_val));
   // R8: filtered value only moves toward a differing synchronised input
   p_filter_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(f_val) |-> ($past(s_val) != $past(f_val)));
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic en,
   input  logic typ,
   input  logic pol,
   input  logic clr,
   output logic req
);
   logic lvl_q;
   logic edge_q;
   logic hit_edge;
   logic active_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign hit_edge   = pol ? (lvl & ~lvl_q) : (~lvl & lvl_q);
   assign active_lvl = pol ? lvl : ~lvl;

   // new edge wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                edge_q <= 1'b0;
      else if (!en)              edge_q <= 1'b0;
      else if (typ && hit_edge)  edge_q <= 1'b1;
      else if (clr)              edge_q <= 1'b0;
   end

   assign req = en & (typ ? edge_q : active_lvl);

   // R5: a disabled line drops its latched edge
   p_disable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !edge_q);
   // R6: a latched edge persists until cleared or disabled
   p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && edge_q && !clr) |=> edge_q);
endmodule

// File: rtl/irq_debounce_agg.sv
module irq_debounce_agg #(
   parameter int unsigned NLINES      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DBNC_RESET  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NLINES-1:0] irq_in,
   output logic              irq_out
);
   import irq_agg_pkg::*;

   if (NLINES < 1 || NLINES > DATA_W) begin : g_bad_lines
      $error("NLINES must be between 1 and DATA_W");
   end
   if (CNT_W > DATA_W) begin : g_bad_cntw
      $error("CNT_W must not exceed DATA_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover the register map");
   end

   localparam logic [CNT_W-1:0] DBNC_INIT = CNT_W'(DBNC_RESET);

   logic [NLINES-1:0] en_q, mask_q, type_q, pol_q;
   logic [CNT_W-1:0]  dbnc_q;
   logic [NLINES-1:0] filt, raw, clr_vec, stat;
   logic              wr_en;

   assign wr_en = reg_valid & reg_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         mask_q <= '1;
         type_q <= '0;
         pol_q  <= '1;
         dbnc_q <= DBNC_INIT;
      end else if (wr_en) begin
         if (reg_addr == ADDR_W'(OFS_ENABLE)) en_q   <= reg_wdata[NLINES-1:0];
         if (reg_addr == ADDR_W'(OFS_MASK))   mask_q <= reg_wdata[NLINES-1:0];
         if (reg_addr == ADDR_W'(OFS_TYPE))   type_q <= reg_wdata[NLINES-1:0];
         if (reg_addr == ADDR_W'(OFS_POL))    pol_q  <= reg_wdata[NLINES-1:0];
         if (reg_addr == ADDR_W'(OFS_DBNC))   dbnc_q <= reg_wdata[CNT_W-1:0];
      end
   end

   assign clr_vec = (wr_en && reg_addr == ADDR_W'(OFS_ECLR)) ?
                    reg_wdata[NLINES-1:0] : '0;

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      irq_sync_debounce #(
         .CNT_W       (CNT_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (irq_in[i]),
         .limit (dbnc_q),
         .dout  (filt[i])
      );
      irq_qualify u_qual (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl   (filt[i]),
         .en    (en_q[i]),
         .typ   (type_q[i]),
         .pol   (pol_q[i]),
         .clr   (clr_vec[i]),
         .req   (raw[i])
      );
   end

   assign stat    = raw & ~mask_q;
   assign irq_out = |stat;

   always_comb begin
      case (reg_addr)
         ADDR_W'(OFS_ENABLE): reg_rdata = DATA_W'(en_q);
         ADDR_W'(OFS_MASK):   reg_rdata = DATA_W'(mask_q);
         ADDR_W'(OFS_TYPE):   reg_rdata = DATA_W'(type_q);
         ADDR_W'(OFS_POL):    reg_rdata = DATA_W'(pol_q);
         ADDR_W'(OFS_STAT):   reg_rdata = DATA_W'(stat);
         ADDR_W'(OFS_RAW):    reg_rdata = DATA_W'(raw);
         ADDR_W'(OFS_DBNC):   reg_rdata = DATA_W'(dbnc_q);
         default:             reg_rdata = '0;
      endcase
   end

   // R4: with every line masked the output stays low
   p_all_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !irq_out);
   // R5: with every line disabled the output stays low
   p_all_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq_out);
endmodule

// File: tb/tb_irq_debounce_agg.sv
module tb_irq_debounce_agg;
   localparam int L = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic        reg_write = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] irq_in = '0;
   logic        irq_out;

   irq_debounce_agg dut (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_in(irq_in), .irq_out(irq_out)
   );

   always #5 clk = ~clk;

   typedef struct {
      logic        chk_rd;
      logic [31:0] exp_rd;
      logic        exp_irq;
      string       tag;
   } item_t;

   item_t q[$];
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // monitor: one expected item per cycle, sampled at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() != 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if ((it.chk_rd && reg_rdata !== it.exp_rd) || irq_out !== it.exp_irq) begin
               failures++;
               $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b (rd checked=%b)",
                        it.tag, reg_rdata, irq_out, it.exp_rd, it.exp_irq, it.chk_rd);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      tick(1);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic expect_rd(input logic [7:0] a, input logic [31:0] e,
                            input logic ei, input string tag);
      item_t it;
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      it.chk_rd = 1'b1; it.exp_rd = e; it.exp_irq = ei; it.tag = tag;
      q.push_back(it);
      tick(1);
      reg_valid = 1'b0;
   endtask

   task automatic expect_irq(input logic ei, input string tag);
      item_t it;
      it.chk_rd = 1'b0; it.exp_rd = '0; it.exp_irq = ei; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic settle();
      tick(12);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      expect_rd(8'h30, 32'h0, 1'b0, "R1 enable reset");
      expect_rd(8'h34, 32'hFFFF_FFFF, 1'b0, "R1 mask reset");
      expect_rd(8'h38, 32'h0, 1'b0, "R1 type reset");
      expect_rd(8'h3C, 32'hFFFF_FFFF, 1'b0, "R1 polarity reset");
      expect_rd(8'h48, 32'h2, 1'b0, "R1 debounce reset");
      expect_rd(8'h40, 32'h0, 1'b0, "R1 masked status reset");
      expect_rd(8'h44, 32'h0, 1'b0, "R1 raw status reset");
      // R2 readback
      wr(8'h48, L);
      expect_rd(8'h48, L, 1'b0, "R2 debounce readback");
      wr(8'h3C, 32'hA5A5_5A5A);
      expect_rd(8'h3C, 32'hA5A5_5A5A, 1'b0, "R2 polarity readback");
      expect_rd(8'h4C, 32'h0, 1'b0, "R2 edge-clear reads zero");
      expect_rd(8'h50, 32'h0, 1'b0, "R2 unmapped reads zero");
      // R10 bring-up
      irq_in = 32'hFFFF_FFF2;
      wr(8'h34, 32'hFFFF_FFFF);
      wr(8'h34, ~32'h0D);
      wr(8'h38, 32'h0);
      wr(8'h3C, 32'hFFFF_FFFF);
      wr(8'h30, 32'h0D);
      expect_rd(8'h30, 32'h0D, 1'b0, "R2 enable readback");
      settle();
      expect_rd(8'h44, 32'h0, 1'b0, "R10 unconnected raw quiet");
      expect_rd(8'h40, 32'h0, 1'b0, "R10 unconnected masked quiet");
      // R3 active-high level on line 2, R9 output
      irq_in = 32'hFFFF_FFF6;
      settle();
      expect_rd(8'h44, 32'h4, 1'b1, "R3 level high raw");
      expect_rd(8'h40, 32'h4, 1'b1, "R9 masked status and output");
      // R4 mask
      wr(8'h34, ~32'h09);
      expect_rd(8'h40, 32'h0, 1'b0, "R4 masked line hidden");
      expect_rd(8'h44, 32'h4, 1'b0, "R4 raw still visible");
      wr(8'h34, ~32'h0D);
      // R3 active-low on line 0
      wr(8'h3C, 32'hFFFF_FFFE);
      settle();
      expect_rd(8'h44, 32'h5, 1'b1, "R3 active-low level");
      irq_in = 32'hFFFF_FFF7;
      settle();
      expect_rd(8'h44, 32'h4, 1'b1, "R3 active-low released");
      irq_in = 32'hFFFF_FFF2;
      wr(8'h3C, 32'hFFFF_FFFF);
      settle();
      expect_rd(8'h44, 32'h0, 1'b0, "R3 all idle");
      // R8 latency with L=4 on line 3
      irq_in = 32'hFFFF_FFFA;
      tick(1 + L);
      expect_irq(1'b0, "R8 not before L+2 edges");
      tick(1);
      expect_irq(1'b1, "R8 accepted at L+2 edges");
      tick(1);
      irq_in = 32'hFFFF_FFF2;
      settle();
      expect_irq(1'b0, "R8 released");
      tick(1);
      // R8 glitch shorter than L
      irq_in = 32'hFFFF_FFFA;
      tick(L - 1);
      irq_in = 32'hFFFF_FFF2;
      for (int i = 0; i < 10; i++) begin
         expect_irq(1'b0, "R8 glitch rejected");
         tick(1);
      end
      // R8 length zero acts as one
      wr(8'h48, 32'h0);
      irq_in = 32'hFFFF_FFFA;
      tick(2);
      expect_irq(1'b0, "R8 zero length early");
      tick(1);
      expect_irq(1'b1, "R8 zero length accepted");
      tick(1);
      irq_in = 32'hFFFF_FFF2;
      wr(8'h48, L);
      settle();
      // R6 rising edge on line 3
      wr(8'h38, 32'h8);
      irq_in = 32'hFFFF_FFFA;
      settle();
      expect_rd(8'h44, 32'h8, 1'b1, "R6 rising edge latched");
      irq_in = 32'hFFFF_FFF2;
      settle();
      expect_rd(8'h44, 32'h8, 1'b1, "R6 latch holds after release");
      // R7 edge clear
      wr(8'h4C, 32'h4);
      expect_rd(8'h44, 32'h8, 1'b1, "R7 other bit clear no effect");
      wr(8'h4C, 32'h8);
      expect_rd(8'h44, 32'h0, 1'b0, "R7 clear removes latch");
      // R6 falling edge
      wr(8'h3C, 32'hFFFF_FFF7);
      irq_in = 32'hFFFF_FFFA;
      settle();
      expect_rd(8'h44, 32'h0, 1'b0, "R6 rising ignored in falling mode");
      irq_in = 32'hFFFF_FFF2;
      settle();
      expect_rd(8'h44, 32'h8, 1'b1, "R6 falling edge latched");
      wr(8'h4C, 32'h8);
      // R5 disable discards latch
      wr(8'h3C, 32'hFFFF_FFFF);
      irq_in = 32'hFFFF_FFFA;
      settle();
      expect_rd(8'h44, 32'h8, 1'b1, "R5 setup edge latched");
      wr(8'h30, 32'h05);
      expect_rd(8'h44, 32'h0, 1'b0, "R5 disabled line quiet");
      wr(8'h30, 32'h0D);
      expect_rd(8'h44, 32'h0, 1'b0, "R5 latch not restored");
      wr(8'h38, 32'h0);
      wr(8'h30, 32'h05);
      expect_rd(8'h44, 32'h0, 1'b0, "R5 disabled level line quiet");
      wr(8'h30, 32'h0D);
      expect_rd(8'h44, 32'h8, 1'b1, "R5 level line re-enabled");
      tick(3);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule